// File: doc/BRIEF.md
# SPI-to-NAND Bus Bridge

The bridge lets a host SPI master reach a parallel 8-bit NAND flash bus. It runs on a fast system clock and oversamples the SPI pins. Each transaction is framed by chip select. The first byte of a frame is an opcode, and it picks one of four actions:

- stream write data onto the NAND data bus, with one write strobe per byte;
- stream NAND read data back to the host, with a read strobe per byte;
- stream NAND read data back to the host after a longer idle preamble;
- load an 8-bit configuration register.

The configuration register drives the NAND command-latch, address-latch and active-low chip-enable lines. It also drives a fan enable and four active-low LEDs.

Write data arrives at two bits per SPI clock on a pair of data lines, which halves the time spent on each byte. Read data is prefetched: the NAND read for the next byte is launched one byte early, so the value is captured before its first bit must appear on the host data-out line. The NAND ready/busy line and the host's clock division are handled outside this block.

There is no back-pressure on either side. The host paces every byte with its own clock. The NAND strobes always complete inside the time of one SPI byte, provided each SCK level is held for at least 4 system clocks.

Top module: `spinand_bridge`

## Requirements
- R1: After reset the configuration register holds 0x8F. So chip enable is high, command latch, address latch and fan are low, and all four LED outputs are high. Write and read strobes are high, the data bus is not driven, and the host data-out line is low.
- R2: The bridge samples the host data line on each rising SCK edge while chip select is low, most significant bit first. The opcode byte always uses one bit per clock. The bridge changes its data-out line only just after a rising edge, so the value holds until the next rising edge. Each SCK level must last at least 4 system clocks.
- R3: Opcode 0x09 loads the next byte into the configuration register. The bit map is: bit 7 drives the active-low chip enable, bit 6 the command latch, bit 5 the address latch, and bit 4 the fan enable. Bits 3 down to 0 drive `led_n[3]` down to `led_n[0]`.
- R4: After opcode 0x08, every data byte takes four SCK clocks. On each clock, `spi_mosi` carries the higher bit of the pair and `spi_mosi2` the lower bit. Each byte is placed on `nand_dq_o` with one write strobe. The data-out line stays low for the whole frame, so the host reads back 0x00.
- R5: After opcode 0x0A and one idle byte, each byte the host clocks returns the next NAND read value, in the order the reads were taken.
- R6: After opcode 0x0B and four idle bytes, each byte the host clocks returns the next NAND read value, in order.
- R7: Each write strobe stays low for at least 2 system clocks. `nand_dq_oe` is high, and `nand_dq_o` is stable, while the strobe is low and at its rising edge.
- R8: Raising chip select drops any partial byte with no effect. The next frame begins again with an opcode.
- R9: An opcode other than 0x08 to 0x0B makes the bridge ignore the rest of the frame. It issues no write or read strobe, and the data-out line stays low.
- R10: The first NAND read of a read frame is launched at the end of the opcode. One more read is launched at the end of the last idle byte and at the end of every data byte. A frame with N data bytes therefore gives N+2 read strobes, each low for at least 2 system clocks.
- R11: Bytes after the configuration byte of an 0x09 frame are ignored and leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Host SPI clock |
| spi_cs_n | input | 1 | Host chip select, active low |
| spi_mosi | input | 1 | Host data line; the higher bit of each pair in a dual write |
| spi_mosi2 | input | 1 | Second host data line; the lower bit of each pair in a dual write |
| spi_miso | output | 1 | Data to the host |
| nand_dq_o | output | 8 | NAND data bus, outgoing |
| nand_dq_oe | output | 1 | NAND data bus drive enable |
| nand_dq_i | input | 8 | NAND data bus, incoming |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| fan_en | output | 1 | Fan enable |
| led_n | output | 4 | Active-low LED drives |

## Verification
A bit counter that has slipped or a wrong dual-line mode shows at once as wrong bytes on `nand_dq_o` at the very next write strobe. A slipped count also shows as a missing strobe, or one strobe too many, before chip select rises. A bad decoder state shows within one byte in several ways: a configuration value on the wrong pins, strobes during an ignored frame, or nonzero data-out bits. A broken prefetch chain shows on the host line as read bytes that are shifted by one place in the sequence. It also shows as a read-strobe count other than N+2 when the frame closes.

// File: rtl/spinand_pkg.sv
`timescale 1ns/1ps
package spinand_pkg;
  localparam logic [7:0] OPC_WRITE = 8'h08;
  localparam logic [7:0] OPC_CFG   = 8'h09;
  localparam logic [7:0] OPC_READ  = 8'h0A;
  localparam logic [7:0] OPC_FREAD = 8'h0B;
  localparam logic [7:0] CFG_RESET = 8'h8F;

  typedef struct packed {
    logic       ce_n;
    logic       cle;
    logic       ale;
    logic       fan;
    logic [3:0] led_n;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_OPC, ST_CFG, ST_WR, ST_IDLE, ST_RD, ST_IGN
  } dec_state_e;

  typedef enum logic [2:0] {
    SB_IDLE, SB_WSET, SB_WLOW, SB_WHOLD, SB_RLOW
  } strobe_state_e;
endpackage

// File: rtl/spinand_sync.sv
`timescale 1ns/1ps
module spinand_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spinand_shifter.sv
`timescale 1ns/1ps
module spinand_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              mosi2_s,
  input  logic              dual,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_data,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val,
  output logic              miso
);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int LAST_S = DATA_W - 1;
  localparam int LAST_D = DATA_W / 2 - 1;

  logic              sck_q;
  logic              rise;
  logic              last;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_q, rx_nx, tx_q;

  assign rise  = sck_s & ~sck_q;
  assign last  = dual ? (bit_cnt == CNT_W'(LAST_D)) : (bit_cnt == CNT_W'(LAST_S));
  assign rx_nx = dual ? {rx_q[DATA_W-3:0], mosi_s, mosi2_s} : {rx_q[DATA_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      bit_cnt   <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      byte_done <= 1'b0;
      byte_val  <= '0;
    end else begin
      sck_q     <= sck_s;
      byte_done <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
        rx_q    <= '0;
        tx_q    <= '0;
      end else begin
        if (rise) begin
          rx_q <= rx_nx;
          if (last) begin
            bit_cnt   <= '0;
            byte_done <= 1'b1;
            byte_val  <= rx_nx;
          end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
            tx_q    <= tx_q << 1;
          end
        end
        if (tx_load) tx_q <= tx_data;
      end
    end
  end

  assign miso = tx_q[DATA_W-1];
endmodule

// File: rtl/spinand_strobe.sv
`timescale 1ns/1ps
module spinand_strobe
  import spinand_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PULSE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int CW = $clog2(PULSE_W + 1);

  strobe_state_e sb_q;
  logic [CW-1:0] cnt_q;
  logic          pulse_end;

  assign pulse_end = (cnt_q == CW'(PULSE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_q    <= SB_IDLE;
      cnt_q   <= '0;
      dq_o    <= '0;
      rd_data <= '0;
    end else begin
      case (sb_q)
        SB_IDLE: begin
          cnt_q <= '0;
          if (wr_go) begin
            dq_o <= wr_data;
            sb_q <= SB_WSET;
          end else if (rd_go) begin
            sb_q <= SB_RLOW;
          end
        end
        SB_WSET: sb_q <= SB_WLOW;
        SB_WLOW: begin
          if (pulse_end) sb_q <= SB_WHOLD;
          else           cnt_q <= cnt_q + CW'(1);
        end
        SB_WHOLD: sb_q <= SB_IDLE;
        SB_RLOW: begin
          if (pulse_end) begin
            rd_data <= dq_i;
            sb_q    <= SB_IDLE;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: sb_q <= SB_IDLE;
      endcase
    end
  end

  assign we_n  = (sb_q != SB_WLOW);
  assign re_n  = (sb_q != SB_RLOW);
  assign dq_oe = (sb_q == SB_WSET) || (sb_q == SB_WLOW) || (sb_q == SB_WHOLD);
  assign busy  = (sb_q != SB_IDLE);
endmodule

// File: rtl/spinand_bridge.sv
`timescale 1ns/1ps
module spinand_bridge
  import spinand_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STROBE_W    = 2,
  parameter int SLOW_IDLE   = 1,
  parameter int FAST_IDLE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              spi_mosi2,
  output logic              spi_miso,
  output logic [DATA_W-1:0] nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_i,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_ce_n,
  output logic              fan_en,
  output logic [3:0]        led_n
);
  localparam int IDLE_MAX = (FAST_IDLE > SLOW_IDLE) ? FAST_IDLE : SLOW_IDLE;
  localparam int IDLE_W   = $clog2(IDLE_MAX + 1);

  logic              sck_s, cs_n_s, mosi_s, mosi2_s;
  logic              byte_done, dual, tx_load, wr_go, rd_go, busy;
  logic [DATA_W-1:0] byte_val, rd_data;
  logic [IDLE_W-1:0] idle_left;
  logic              idle_last, is_read_opc;
  dec_state_e        st;
  cfg_t              cfg_q;

  spinand_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({spi_sck, spi_cs_n, spi_mosi, spi_mosi2}),
    .q   ({sck_s, cs_n_s, mosi_s, mosi2_s})
  );

  spinand_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_s     (sck_s),
    .cs_n_s    (cs_n_s),
    .mosi_s    (mosi_s),
    .mosi2_s   (mosi2_s),
    .dual      (dual),
    .tx_load   (tx_load),
    .tx_data   (rd_data),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .miso      (spi_miso)
  );

  spinand_strobe #(.DATA_W(DATA_W), .PULSE_W(STROBE_W)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_go   (wr_go),
    .wr_data (byte_val),
    .rd_go   (rd_go),
    .dq_i    (nand_dq_i),
    .dq_o    (nand_dq_o),
    .dq_oe   (nand_dq_oe),
    .we_n    (nand_we_n),
    .re_n    (nand_re_n),
    .rd_data (rd_data),
    .busy    (busy)
  );

  assign dual        = (st == ST_WR);
  assign idle_last   = (idle_left == IDLE_W'(1));
  assign is_read_opc = (byte_val == OPC_READ) || (byte_val == OPC_FREAD);
  assign wr_go       = byte_done && (st == ST_WR);
  assign tx_load     = byte_done && ((st == ST_IDLE && idle_last) || st == ST_RD);
  assign rd_go       = tx_load || (byte_done && st == ST_OPC && is_read_opc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OPC;
      idle_left <= '0;
      cfg_q     <= cfg_t'(CFG_RESET);
    end else if (cs_n_s) begin
      st <= ST_OPC;
    end else if (byte_done) begin
      case (st)
        ST_OPC: begin
          case (byte_val)
            OPC_WRITE: st <= ST_WR;
            OPC_CFG:   st <= ST_CFG;
            OPC_READ: begin
              idle_left <= IDLE_W'(SLOW_IDLE);
              st        <= ST_IDLE;
            end
            OPC_FREAD: begin
              idle_left <= IDLE_W'(FAST_IDLE);
              st        <= ST_IDLE;
            end
            default:   st <= ST_IGN;
          endcase
        end
        ST_CFG: begin
          cfg_q <= cfg_t'(byte_val);
          st    <= ST_IGN;
        end
        ST_IDLE: begin
          if (idle_last) st <= ST_RD;
          else           idle_left <= idle_left - IDLE_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign nand_ce_n = cfg_q.ce_n;
  assign nand_cle  = cfg_q.cle;
  assign nand_ale  = cfg_q.ale;
  assign fan_en    = cfg_q.fan;
  assign led_n     = cfg_q.led_n;
endmodule

// File: rtl/spinand_bridge_chk.sv
`timescale 1ns/1ps
module spinand_bridge_chk
  import spinand_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic [DATA_W-1:0] nand_dq_o,
  input logic              nand_dq_oe,
  input logic              spi_miso,
  input logic              cs_n_s,
  input dec_state_e        st,
  input logic              dual,
  input logic              wr_go,
  input logic              rd_go,
  input logic              busy
);
  a_r7_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> $past(!nand_we_n, 1) && $past(!nand_we_n, 2));

  a_r7_we_data: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe && $stable(nand_dq_o));

  a_r7_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> nand_dq_oe);

  a_r10_re_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_re_n) |-> $past(!nand_re_n, 1) && $past(!nand_re_n, 2));

  a_r9_ign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGN) |-> !spi_miso && !$fell(nand_we_n) && !$fell(nand_re_n));

  a_r4_wr_miso_low: assert property (@(posedge clk) disable iff (!rst_n)
    dual |-> !spi_miso);

  a_r8_cs_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_s) |=> (st == ST_OPC));

  a_r10_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go || rd_go) |-> !busy);
endmodule

bind spinand_bridge spinand_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_o  (nand_dq_o),
  .nand_dq_oe (nand_dq_oe),
  .spi_miso   (spi_miso),
  .cs_n_s     (cs_n_s),
  .st         (st),
  .dual       (dual),
  .wr_go      (wr_go),
  .rd_go      (rd_go),
  .busy       (busy)
);

// File: tb/spinand_bridge_bench.sv
`timescale 1ns/1ps
module spinand_bridge_bench;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_mosi2 = 1'b0;
  logic       spi_miso;
  logic [7:0] nand_dq_o, nand_dq_i;
  logic       nand_dq_oe, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_ce_n, fan_en;
  logic [3:0] led_n;

  int checks = 0, errors = 0;
  int re_count = 0, we_count = 0;
  bit done = 1'b0;
  logic [7:0] wr_q[$];
  realtime we_fall_t;

  always #2.5 clk = ~clk;

  spinand_bridge u_spinand_bridge (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_mosi2(spi_mosi2), .spi_miso(spi_miso),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_ce_n(nand_ce_n), .fan_en(fan_en), .led_n(led_n)
  );

  function automatic logic [7:0] nand_val(int k);
    return 8'(k * 37 + 11);
  endfunction

  assign nand_dq_i = nand_val(re_count);

  always @(posedge nand_re_n) if (rst_n) re_count++;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // write monitor: scoreboard pop on each rising write strobe
  always @(negedge nand_we_n) if (rst_n) we_fall_t = $realtime;
  always @(posedge nand_we_n) begin
    if (rst_n) begin
      we_count++;
      check(($realtime - we_fall_t) >= 10.0, "R7 we width", 32'($realtime - we_fall_t), 10);
      check(nand_dq_oe === 1'b1, "R7 bus driven at strobe edge", 32'(nand_dq_oe), 1);
      if (wr_q.size() == 0) begin
        check(1'b0, "R4 unexpected write strobe", 32'(nand_dq_o), 0);
      end else begin
        logic [7:0] e;
        e = wr_q.pop_front();
        check(nand_dq_o === e, "R4 write byte", 32'(nand_dq_o), 32'(e));
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_on();
    spi_cs_n = 1'b0;
    tick(4);
  endtask

  task automatic cs_off();
    tick(6);
    spi_cs_n = 1'b1;
    tick(10);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, input bit dual,
                           output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      if (dual) begin
        spi_mosi  = tx[7 - 2*i];
        spi_mosi2 = tx[6 - 2*i];
      end else begin
        spi_mosi  = tx[7 - i];
      end
      tick(HALF);
      rx = {rx[6:0], spi_miso};
      spi_sck = 1'b1;
      tick(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input bit dual, output logic [7:0] rx);
    xfer_bits(tx, dual ? 4 : 8, dual, rx);
  endtask

  function automatic logic [7:0] cfg_pins();
    return {nand_ce_n, nand_cle, nand_ale, fan_en, led_n};
  endfunction

  task automatic cfg_frame(input logic [7:0] v, input logic [7:0] extra);
    logic [7:0] rx;
    cs_on();
    xfer(8'h09, 1'b0, rx);
    xfer(v, 1'b0, rx);
    xfer(extra, 1'b0, rx);
    cs_off();
  endtask

  task automatic write_frame(input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input logic [7:0] b3);
    logic [7:0] rx;
    logic [7:0] bytes [4];
    int w0;
    bytes = '{b0, b1, b2, b3};
    w0 = we_count;
    cs_on();
    xfer(8'h08, 1'b0, rx);
    for (int i = 0; i < 4; i++) begin
      wr_q.push_back(bytes[i]);
      xfer(bytes[i], 1'b1, rx);
      check(rx == 8'h00, "R4 readback zero", 32'(rx), 0);
    end
    cs_off();
    check(wr_q.size() == 0, "R4 all bytes strobed", 32'(wr_q.size()), 0);
    check(we_count - w0 == 4, "R4 one strobe per byte", 32'(we_count - w0), 4);
  endtask

  task automatic read_frame(input logic [7:0] opc, input int idles, input int n, input string req);
    logic [7:0] rx;
    int s;
    s = re_count;
    cs_on();
    xfer(opc, 1'b0, rx);
    for (int i = 0; i < idles; i++) xfer(8'h00, 1'b0, rx);
    for (int j = 0; j < n; j++) begin
      xfer(8'h00, 1'b0, rx);
      check(rx == nand_val(s + j), req, 32'(rx), 32'(nand_val(s + j)));
    end
    cs_off();
    check(re_count - s == n + 2, "R10 read strobe count", 32'(re_count - s), 32'(n + 2));
  endtask

  initial begin
    logic [7:0] rx;
    int w0, r0;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    check(cfg_pins() == 8'h8F, "R1 cfg reset", 32'(cfg_pins()), 32'h8F);
    check(nand_we_n && nand_re_n && !nand_dq_oe && !spi_miso, "R1 strobes idle",
          32'({nand_we_n, nand_re_n, nand_dq_oe, spi_miso}), 32'b1100);

    // R3 / R11 config write with a trailing byte
    cfg_frame(8'h65, 8'h12);
    check(cfg_pins() == 8'h65, "R3 R11 cfg load", 32'(cfg_pins()), 32'h65);
    cfg_frame(8'h5A, 8'hFF);
    check(nand_ce_n == 1'b0 && nand_cle == 1'b1 && nand_ale == 1'b0 && fan_en == 1'b1,
          "R3 control pins", 32'({nand_ce_n, nand_cle, nand_ale, fan_en}), 32'b0101);
    check(led_n == 4'hA, "R3 led pins", 32'(led_n), 32'hA);

    // R4 / R7 dual-line writes, two patterns
    write_frame(8'hA5, 8'h3C, 8'h00, 8'hFF);
    write_frame(8'h81, 8'h7E, 8'h96, 8'h01);

    // R5 read, R6 fast read, R10 strobe counts
    read_frame(8'h0A, 1, 3, "R5 read data");
    read_frame(8'h0B, 4, 5, "R6 fast read data");
    read_frame(8'h0A, 1, 1, "R5 single byte read");

    // R8 abort partial config byte
    cs_on();
    xfer(8'h09, 1'b0, rx);
    xfer_bits(8'hFF, 5, 1'b0, rx);
    cs_off();
    check(cfg_pins() == 8'h5A, "R8 partial cfg dropped", 32'(cfg_pins()), 32'h5A);
    // R8 abort partial write byte
    w0 = we_count;
    cs_on();
    xfer(8'h08, 1'b0, rx);
    xfer_bits(8'hC3, 3, 1'b1, rx);
    cs_off();
    check(we_count == w0, "R8 partial write dropped", 32'(we_count - w0), 0);
    // R8 next frame restarts at opcode
    cfg_frame(8'h8F, 8'h00);
    check(cfg_pins() == 8'h8F, "R8 restart after abort", 32'(cfg_pins()), 32'h8F);

    // R9 unknown opcode
    w0 = we_count;
    r0 = re_count;
    cs_on();
    xfer(8'h5A, 1'b0, rx);
    xfer(8'hC3, 1'b0, rx);
    check(rx == 8'h00, "R9 miso low", 32'(rx), 0);
    xfer(8'h0A, 1'b0, rx);
    check(rx == 8'h00, "R9 miso low after opcode-like byte", 32'(rx), 0);
    cs_off();
    check(we_count == w0 && re_count == r0, "R9 no strobes",
          32'((we_count - w0) + (re_count - r0)), 0);
    check(cfg_pins() == 8'h8F, "R9 cfg untouched", 32'(cfg_pins()), 32'h8F);

    // R2 frame after idle: read still works in order
    read_frame(8'h0A, 1, 2, "R2 R5 msb-first read");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule